// File: doc/BRIEF.md
# Audio Sample FIFO with Burst-Threshold DMA Request

This block buffers audio sample words between a serial audio port and a DMA engine. Words go in through a push strobe and come out through a show-ahead pop port. One configuration input sets the direction. In receive, the port fills the FIFO and DMA drains it. In transmit, DMA fills the FIFO and the port drains it. The block raises a DMA request when one whole burst can move: in receive when enough words are stored, in transmit when enough free space exists. It drops the request once that burst has moved.

The burst size is resolved from configuration. With burst mode off it is one word. With burst mode on it is the packet length when that is non-zero, or else the period length in bytes converted to words for the selected sample width (16-bit or 32-bit). The result is always limited by a per-direction ceiling. A sequential divider turns the word count into whole audio frames for a given channel count, so software can read the buffering latency. Sticky overflow and underflow flags record pushes into a full FIFO and pops from an empty one.

The request controller has two states. In `BS_IDLE` it waits. It takes transition IDLE->BURST when the available amount reaches the burst size and no transfer happens in that cycle. In `BS_BURST` the request is high. It takes transition BURST->IDLE on the transfer that completes the burst. The frame divider also has two states. `DV_LOAD` snapshots the fill level and channel count and takes LOAD->STEP. `DV_STEP` runs one restoring-division step per cycle and takes STEP->LOAD after the last step, publishing the quotient.

Top module: `audio_dma_fifo`

## Requirements
- R1: Words pop out in the order they were pushed. `fill_level` counts stored words and never exceeds DEPTH (default 128; 1280 is also a legal depth).
- R2: With `cfg_wide`=0 (16-bit samples) only the low 16 bits of a pushed word are stored, and the upper bits pop out as zero. With `cfg_wide`=1 all 32 bits are kept.
- R3: `thr_eff` is at least 1 and never exceeds `cfg_max_thr`. A `cfg_max_thr` of 0, or one above DEPTH, means a limit of DEPTH.
- R4: With `cfg_thr_mode`=1 and a non-zero `cfg_packet_words`, the burst size is the packet length (before the R3 limit).
- R5: With `cfg_thr_mode`=1 and `cfg_packet_words`=0, the burst size is `cfg_period_bytes`/2 for 16-bit samples or `cfg_period_bytes`/4 for 32-bit samples (before the R3 limit).
- R6: With `cfg_thr_mode`=0 the burst size is 1 word.
- R7: In receive (`cfg_dir_rx`=1), `dma_req` rises one cycle after an idle cycle in which `fill_level` >= `thr_eff` and no pop completed. It stays low while `fill_level` < `thr_eff`.
- R8: In transmit (`cfg_dir_rx`=0), the same rule applies to free space (DEPTH - `fill_level`) and completed pushes.
- R9: `dma_req` falls right after the transfer that completes exactly `thr_eff` transfers (pops in receive, pushes in transmit). It stays low for at least one cycle before it can rise again.
- R10: A push into a full FIFO is dropped and sets `ovf_flag`. The flag stays set until `clr_ovf` is pulsed.
- R11: A pop from an empty FIFO changes nothing stored and sets `unf_flag`. The flag stays set until `clr_unf` is pulsed.
- R12: `delay_frames` becomes floor(`fill_level` / channels) within 2*(CW+1) cycles of the fill level settling. A `cfg_channels` of 0 counts as 1.
- R13: After reset the FIFO is empty, `dma_req` is low, both flags are clear and `delay_frames` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dir_rx | input | 1 | 1 = receive direction, 0 = transmit direction |
| cfg_thr_mode | input | 1 | 1 = burst-threshold mode, 0 = one word per request |
| cfg_wide | input | 1 | 1 = 32-bit samples, 0 = 16-bit samples |
| cfg_packet_words | input | CW | Packet length in words, 0 = none |
| cfg_period_bytes | input | PBW | Period length in bytes |
| cfg_max_thr | input | CW | Ceiling on the burst size for this direction |
| cfg_channels | input | CHW | Channels per audio frame |
| push_en | input | 1 | Push strobe |
| push_data | input | DW | Word to push |
| pop_en | input | 1 | Pop strobe |
| pop_data | output | DW | Word at the head of the FIFO |
| clr_ovf | input | 1 | Write-one clear of the overflow flag |
| clr_unf | input | 1 | Write-one clear of the underflow flag |
| dma_req | output | 1 | Burst request to the DMA engine |
| fill_level | output | CW | Number of stored words |
| thr_eff | output | CW | Resolved burst size in words |
| delay_frames | output | CW | Stored words divided by the channel count |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
Each source of the burst size is exercised in turn: a plain packet length, a 64-byte period at both sample widths (which tells the /2 and /4 conversions apart), an oversized period and packet that hit the ceiling, and disabled mode. The request logic is run in receive just below and at the burst size, and with two back-to-back bursts, which exposes the one-cycle gap and the exact transfer count. In transmit it is run with free space one short of and then equal to the burst size. The FIFO is filled to capacity, pushed once more and then drained completely, all against a queue of expected words, so ordering, 16-bit masking and the dropped word are seen at the pop port. The frame divider is read at three channel counts, including a count that leaves a remainder and the zero count.

// File: rtl/adf_pkg.sv
`timescale 1ns/1ps
package adf_pkg;
    typedef enum logic {
        BS_IDLE  = 1'b0,
        BS_BURST = 1'b1
    } burst_state_e;

    typedef enum logic {
        DV_LOAD = 1'b0,
        DV_STEP = 1'b1
    } div_state_e;
endpackage

// File: rtl/adf_store.sv
`timescale 1ns/1ps
module adf_store #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wide,
    input  logic          push_en,
    input  logic [DW-1:0] push_data,
    input  logic          pop_en,
    input  logic          clr_ovf,
    input  logic          clr_unf,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] fill,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          ovf,
    output logic          unf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int HW = DW / 2;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, empty;
    logic [DW-1:0] wr_word;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push_en & ~full;
    assign pop_ok  = pop_en & ~empty;
    assign wr_word = cfg_wide ? push_data : {{(DW-HW){1'b0}}, push_data[HW-1:0]};

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            ovf <= (ovf & ~clr_ovf) | (push_en & full);
            unf <= (unf & ~clr_unf) | (pop_en & empty);
        end
    end

    assign pop_data = mem[rd_ptr];
    assign fill     = count;

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_ovf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && full) |=> ovf);
    p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && full && !pop_en) |=> (count == $past(count)));
    p_unf_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && empty) |=> unf);
    p_empty_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && empty && !push_en) |=> (count == '0));
endmodule

// File: rtl/adf_thresh.sv
`timescale 1ns/1ps
module adf_thresh #(
    parameter int DEPTH = 128,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int PBW   = 16
) (
    input  logic           thr_mode,
    input  logic           wide,
    input  logic [CW-1:0]  packet_words,
    input  logic [PBW-1:0] period_bytes,
    input  logic [CW-1:0]  max_thr,
    output logic [CW-1:0]  thr
);
    localparam int RW = (PBW > CW) ? PBW : CW;

    logic [RW-1:0] period_words;
    logic [RW-1:0] raw;
    logic [RW-1:0] limit;

    always_comb begin
        period_words = wide ? RW'(period_bytes >> 2) : RW'(period_bytes >> 1);
        if (!thr_mode)
            raw = RW'(1);
        else if (packet_words != '0)
            raw = RW'(packet_words);
        else
            raw = period_words;

        if (max_thr == '0 || max_thr > CW'(DEPTH))
            limit = RW'(DEPTH);
        else
            limit = RW'(max_thr);

        if (raw > limit)
            thr = CW'(limit);
        else if (raw == '0)
            thr = CW'(1);
        else
            thr = CW'(raw);
    end
endmodule

// File: rtl/adf_burst_fsm.sv
`timescale 1ns/1ps
module adf_burst_fsm
    import adf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_rx,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] thr,
    input  logic          push_ok,
    input  logic          pop_ok,
    output logic          dma_req
);
    burst_state_e state, state_nx;
    logic [CW-1:0] avail;
    logic          xfer;
    logic          start_ok;
    logic          last_xfer;
    logic [CW-1:0] done_cnt;
    logic [CW-1:0] thr_q;

    assign xfer      = dir_rx ? pop_ok : push_ok;
    assign avail     = dir_rx ? fill : CW'(DEPTH) - fill;
    assign start_ok  = (avail >= thr) && !xfer;
    assign last_xfer = xfer && (done_cnt == thr_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            BS_IDLE:  if (start_ok)  state_nx = BS_BURST;
            BS_BURST: if (last_xfer) state_nx = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_cnt <= '0;
            thr_q    <= CW'(1);
        end else begin
            unique case (state)
                BS_IDLE: begin
                    done_cnt <= '0;
                    thr_q    <= thr;
                end
                BS_BURST: if (xfer) done_cnt <= done_cnt + 1'b1;
            endcase
        end
    end

    always_comb begin
        dma_req = (state == BS_BURST);
    end

    p_req_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(start_ok));
    p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> $past(xfer));
    p_burst_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (done_cnt < thr_q));
endmodule

// File: rtl/adf_frame_div.sv
`timescale 1ns/1ps
module adf_frame_div
    import adf_pkg::*;
#(
    parameter int CW  = 8,
    parameter int CHW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  fill,
    input  logic [CHW-1:0] channels,
    output logic [CW-1:0]  frames
);
    localparam int SW = $clog2(CW) + 1;
    localparam int PW = CW + CHW;

    div_state_e    st, st_nx;
    logic [CW-1:0]  snap, quo, rem;
    logic [CHW-1:0] dv;
    logic [SW-1:0]  step;
    logic [CW:0]    trial;
    logic           ge;
    logic [CW-1:0]  rem_n, quo_n;
    logic           last_step;
    logic           valid_q;

    assign trial     = {rem, quo[CW-1]};
    assign ge        = trial >= (CW+1)'(dv);
    assign rem_n     = ge ? CW'(trial - (CW+1)'(dv)) : trial[CW-1:0];
    assign quo_n     = {quo[CW-2:0], ge};
    assign last_step = (step == SW'(CW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= DV_LOAD;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            DV_LOAD: st_nx = DV_STEP;
            DV_STEP: if (last_step) st_nx = DV_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap    <= '0;
            quo     <= '0;
            rem     <= '0;
            dv      <= CHW'(1);
            step    <= '0;
            frames  <= '0;
            valid_q <= 1'b0;
        end else begin
            unique case (st)
                DV_LOAD: begin
                    snap <= fill;
                    quo  <= fill;
                    rem  <= '0;
                    dv   <= (channels == '0) ? CHW'(1) : channels;
                    step <= '0;
                end
                DV_STEP: begin
                    rem  <= rem_n;
                    quo  <= quo_n;
                    step <= step + 1'b1;
                    if (last_step) begin
                        frames  <= quo_n;
                        valid_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    p_div_identity_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DV_LOAD && valid_q) |->
            ((PW'(frames) * PW'(dv) + PW'(rem)) == PW'(snap)) && (PW'(rem) < PW'(dv)));
endmodule

// File: rtl/audio_dma_fifo.sv
`timescale 1ns/1ps
module audio_dma_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    parameter int PBW   = 16,
    parameter int CHW   = 5,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_dir_rx,
    input  logic           cfg_thr_mode,
    input  logic           cfg_wide,
    input  logic [CW-1:0]  cfg_packet_words,
    input  logic [PBW-1:0] cfg_period_bytes,
    input  logic [CW-1:0]  cfg_max_thr,
    input  logic [CHW-1:0] cfg_channels,
    input  logic           push_en,
    input  logic [DW-1:0]  push_data,
    input  logic           pop_en,
    output logic [DW-1:0]  pop_data,
    input  logic           clr_ovf,
    input  logic           clr_unf,
    output logic           dma_req,
    output logic [CW-1:0]  fill_level,
    output logic [CW-1:0]  thr_eff,
    output logic [CW-1:0]  delay_frames,
    output logic           ovf_flag,
    output logic           unf_flag
);
    logic push_ok, pop_ok;

    adf_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wide (cfg_wide),
        .push_en  (push_en),
        .push_data(push_data),
        .pop_en   (pop_en),
        .clr_ovf  (clr_ovf),
        .clr_unf  (clr_unf),
        .pop_data (pop_data),
        .fill     (fill_level),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .ovf      (ovf_flag),
        .unf      (unf_flag)
    );

    adf_thresh #(.DEPTH(DEPTH), .CW(CW), .PBW(PBW)) u_thresh (
        .thr_mode    (cfg_thr_mode),
        .wide        (cfg_wide),
        .packet_words(cfg_packet_words),
        .period_bytes(cfg_period_bytes),
        .max_thr     (cfg_max_thr),
        .thr         (thr_eff)
    );

    adf_burst_fsm #(.DEPTH(DEPTH), .CW(CW)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_rx (cfg_dir_rx),
        .fill   (fill_level),
        .thr    (thr_eff),
        .push_ok(push_ok),
        .pop_ok (pop_ok),
        .dma_req(dma_req)
    );

    adf_frame_div #(.CW(CW), .CHW(CHW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .fill    (fill_level),
        .channels(cfg_channels),
        .frames  (delay_frames)
    );

    p_thr_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_eff >= CW'(1)) && (thr_eff <= CW'(DEPTH)) &&
        ((cfg_max_thr == '0) || (thr_eff <= cfg_max_thr)));
    p_idle_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_thr_mode |-> (thr_eff == CW'(1)));
endmodule

// File: tb/tb_audio_dma_fifo.sv
`timescale 1ns/1ps
module tb_audio_dma_fifo;
    localparam int DEPTH = 128;
    localparam int DW    = 32;
    localparam int PBW   = 16;
    localparam int CHW   = 5;
    localparam int CW    = $clog2(DEPTH + 1);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_dir_rx, cfg_thr_mode, cfg_wide;
    logic [CW-1:0]  cfg_packet_words, cfg_max_thr;
    logic [PBW-1:0] cfg_period_bytes;
    logic [CHW-1:0] cfg_channels;
    logic           push_en, pop_en, clr_ovf, clr_unf;
    logic [DW-1:0]  push_data, pop_data;
    logic           dma_req, ovf_flag, unf_flag;
    logic [CW-1:0]  fill_level, thr_eff, delay_frames;

    always #2.5 clk = ~clk;

    audio_dma_fifo #(.DEPTH(DEPTH), .DW(DW), .PBW(PBW), .CHW(CHW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_dir_rx(cfg_dir_rx), .cfg_thr_mode(cfg_thr_mode), .cfg_wide(cfg_wide),
        .cfg_packet_words(cfg_packet_words), .cfg_period_bytes(cfg_period_bytes),
        .cfg_max_thr(cfg_max_thr), .cfg_channels(cfg_channels),
        .push_en(push_en), .push_data(push_data), .pop_en(pop_en), .pop_data(pop_data),
        .clr_ovf(clr_ovf), .clr_unf(clr_unf), .dma_req(dma_req),
        .fill_level(fill_level), .thr_eff(thr_eff), .delay_frames(delay_frames),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    int n_run  = 0;
    int n_fail = 0;
    int wd     = 0;
    logic [DW-1:0] sb_q [$];

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=100000 cycles", wd);
            report();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: called at a falling edge, returns at the next falling edge
    task automatic push_word(input logic [DW-1:0] d, input bit track);
        push_en   = 1'b1;
        push_data = d;
        if (track) sb_q.push_back(cfg_wide ? d : (d & 32'h0000_FFFF));
        @(posedge clk);
        @(negedge clk);
        push_en = 1'b0;
    endtask

    // monitor: compares the head word against the scoreboard, then pops it
    task automatic pop_word(input string tag);
        logic [DW-1:0] exp_w;
        exp_w = sb_q.pop_front();
        chk(tag, pop_data, exp_w);
        pop_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pop_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_dir_rx = 1'b1; cfg_thr_mode = 1'b0; cfg_wide = 1'b0;
        cfg_packet_words = '0; cfg_max_thr = CW'(64);
        cfg_period_bytes = '0; cfg_channels = CHW'(1);
        push_en = 1'b0; pop_en = 1'b0; clr_ovf = 1'b0; clr_unf = 1'b0;
        push_data = '0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);

        // R13 reset state
        chk("R13 fill after reset", 32'(fill_level), 0);
        chk("R13 dma_req after reset", 32'(dma_req), 0);
        chk("R13 ovf after reset", 32'(ovf_flag), 0);
        chk("R13 unf after reset", 32'(unf_flag), 0);
        chk("R13 delay after reset", 32'(delay_frames), 0);

        // burst-size resolution
        #1;
        chk("R6 mode off gives 1", 32'(thr_eff), 1);
        cfg_thr_mode = 1'b1; cfg_packet_words = CW'(12); #1;
        chk("R4 packet length", 32'(thr_eff), 12);
        cfg_packet_words = '0; cfg_period_bytes = 16'd64; cfg_wide = 1'b0; #1;
        chk("R5 period 64B 16-bit", 32'(thr_eff), 32);
        cfg_wide = 1'b1; #1;
        chk("R5 period 64B 32-bit", 32'(thr_eff), 16);
        cfg_wide = 1'b0; cfg_period_bytes = 16'd400; #1;
        chk("R3 clamp to max", 32'(thr_eff), 64);
        cfg_max_thr = '0; cfg_packet_words = CW'(200); #1;
        chk("R3 zero max means depth", 32'(thr_eff), DEPTH);
        cfg_packet_words = '0; cfg_period_bytes = 16'd1; #1;
        chk("R3 zero words gives 1", 32'(thr_eff), 1);
        cfg_max_thr = CW'(64); cfg_packet_words = CW'(4);
        cyc(1);

        // receive burst, 16-bit masking
        push_word(32'hDEAD_BEEF, 1'b1);
        push_word(32'h1234_5678, 1'b1);
        push_word(32'hCAFE_0001, 1'b1);
        cyc(2);
        chk("R7 no request below threshold", 32'(dma_req), 0);
        push_word(32'hFFFF_0002, 1'b1);
        chk("R7 request not yet", 32'(dma_req), 0);
        cyc(1);
        chk("R7 request at threshold", 32'(dma_req), 1);
        chk("R1 fill is 4", 32'(fill_level), 4);
        pop_word("R2 masked word 0");
        pop_word("R2 masked word 1");
        pop_word("R2 masked word 2");
        chk("R9 request held mid burst", 32'(dma_req), 1);
        pop_word("R2 masked word 3");
        chk("R9 request drops after burst", 32'(dma_req), 0);

        // two back-to-back bursts, 32-bit samples
        cfg_wide = 1'b1;
        for (int i = 0; i < 8; i++) push_word(32'h8000_0000 + 32'(i) * 32'h0101_0101, 1'b1);
        for (int i = 0; i < 4; i++) pop_word("R1 order burst A");
        chk("R9 gap after first burst", 32'(dma_req), 0);
        cyc(1);
        chk("R9 second burst starts", 32'(dma_req), 1);
        for (int i = 0; i < 4; i++) pop_word("R2 wide word burst B");
        chk("R9 request low after second burst", 32'(dma_req), 0);

        // fill almost full in receive with a large burst size
        cfg_packet_words = CW'(127); cfg_max_thr = CW'(127);
        for (int i = 0; i < 125; i++) push_word(32'hA500_0000 + 32'(i), 1'b1);
        cyc(2);
        chk("R7 no request at 125 of 127", 32'(dma_req), 0);

        // transmit: free space 3
        cfg_dir_rx = 1'b0; cfg_packet_words = CW'(4); cfg_max_thr = CW'(64);
        cyc(3);
        chk("R8 no request free 3 thr 4", 32'(dma_req), 0);
        cfg_packet_words = CW'(3);
        cyc(1);
        chk("R8 request free 3 thr 3", 32'(dma_req), 1);
        push_word(32'h5A5A_0001, 1'b1);
        push_word(32'h5A5A_0002, 1'b1);
        chk("R9 tx request held", 32'(dma_req), 1);
        push_word(32'h5A5A_0003, 1'b1);
        chk("R9 tx request drops", 32'(dma_req), 0);
        chk("R1 full fill", 32'(fill_level), DEPTH);
        cyc(1);
        chk("R8 no request when full", 32'(dma_req), 0);
        push_word(32'h0BAD_0BAD, 1'b0);
        chk("R10 overflow flag set", 32'(ovf_flag), 1);
        chk("R10 fill unchanged", 32'(fill_level), DEPTH);
        cyc(2);
        chk("R10 overflow sticky", 32'(ovf_flag), 1);

        // frame delay
        cfg_channels = CHW'(3); cyc(30);
        chk("R12 128 words / 3 ch", 32'(delay_frames), 42);
        cfg_channels = CHW'(16); cyc(30);
        chk("R12 128 words / 16 ch", 32'(delay_frames), 8);
        cfg_channels = CHW'(0); cyc(30);
        chk("R12 zero channels as 1", 32'(delay_frames), 128);

        clr_ovf = 1'b1; cyc(1); clr_ovf = 1'b0;
        chk("R10 overflow cleared", 32'(ovf_flag), 0);

        // drain in receive, mode off
        cfg_dir_rx = 1'b1; cfg_thr_mode = 1'b0; #1;
        chk("R6 mode off thr", 32'(thr_eff), 1);
        cyc(1);
        for (int i = 0; i < DEPTH; i++) pop_word("R1 drain order");
        chk("R1 empty after drain", 32'(fill_level), 0);
        cfg_channels = CHW'(2); cyc(30);
        chk("R12 empty delay", 32'(delay_frames), 0);
        pop_en = 1'b1; cyc(1); pop_en = 1'b0;
        chk("R11 underflow flag set", 32'(unf_flag), 1);
        chk("R11 fill stays 0", 32'(fill_level), 0);
        cyc(1);
        chk("R11 underflow sticky", 32'(unf_flag), 1);
        clr_unf = 1'b1; cyc(1); clr_unf = 1'b0;
        chk("R11 underflow cleared", 32'(unf_flag), 0);
        push_word(32'h7777_8888, 1'b1);
        cyc(1);
        chk("R6 single word request", 32'(dma_req), 1);
        pop_word("R1 last word");
        chk("R9 single word burst ends", 32'(dma_req), 0);

        report();
        $finish;
    end
endmodule